// File: doc/BRIEF.md
# Power Button Event Handler

This block turns an active-low power button into system events. The raw button level crosses into the clock domain through a synchronizer and is then filtered by a debounce counter. A debounced press is classified against the current system power state: it becomes a sleep request when the system is running, or a wake event when the system is in any sleep state. Holding the button down past a long override time raises a forced soft-off request. This request applies whether the system is running or sleeping.

All outputs are single-cycle pulses on plain control pins. There is no data stream and no handshake: a consumer must act on a pulse in the cycle it appears. The debounce time and the override time are parameters given in clock cycles, so a fast simulation can use short values. The state machine that later moves the system between power states sits outside this block.

Top module: `pwrbtn_event_ctrl`

## Requirements
- R1: After reset every output is low, and the debounced button level starts at released (high), so an idle high input produces no event.
- R2: A low level on `btn_n` that lasts fewer than `DB_CYCLES` consecutive clock cycles produces no event of any kind.
- R3: A press held at least `DB_CYCLES` cycles while `sys_state` is 2'b00 (running) produces exactly one `sleep_req` pulse and no `wake_evt` pulse.
- R4: A press held at least `DB_CYCLES` cycles while `sys_state` is 2'b01, 2'b10 or 2'b11 (the sleep states and soft-off) produces exactly one `wake_evt` pulse and no `sleep_req` pulse.
- R5: A press held at least `HOLD_CYCLES` cycles produces exactly one `force_off` pulse in any `sys_state`, and the pulse does not repeat however long the button stays down.
- R6: A press released before `HOLD_CYCLES` cycles produces no `force_off` pulse, and it clears the hold count, so a second short press starts the count again from zero.
- R7: Each output pulse is exactly one cycle wide, and `sleep_req` and `wake_evt` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Raw power button, low when pressed, may change asynchronously |
| sys_state | input | 2 | Current power state: 00 running, 01 suspend to RAM, 10 suspend to disk, 11 soft-off |
| sleep_req | output | 1 | One-cycle pulse: a press was seen while running |
| wake_evt | output | 1 | One-cycle pulse: a press was seen while in a sleep state |
| force_off | output | 1 | One-cycle pulse: the button was held past the override time |

## Verification
The last increment of the hold counter and the debounced release can land on the same clock edge. This happens when the button is held for exactly `HOLD_CYCLES` cycles. At that edge the override pulse must still fire once, and the counter must be cleared on the following edge. The bench drives holds of exactly `HOLD_CYCLES` and `HOLD_CYCLES-1` cycles and expects one override for the first and none for the second. Random hold lengths that straddle both thresholds then check the same boundary again.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;
  typedef enum logic [1:0] {
    PST_RUN  = 2'b00,
    PST_SRAM = 2'b01,
    PST_SDSK = 2'b10,
    PST_OFF  = 2'b11
  } pwr_state_e;
endpackage

// File: rtl/pwrbtn_debounce.sv
module pwrbtn_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int DB_CYCLES   = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic level_n,
  output logic press_stb
);
  localparam int DB_W = (DB_CYCLES < 2) ? 1 : $clog2(DB_CYCLES);
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(DB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DB_W-1:0]        cnt_q;
  logic                   lvl_q;
  logic                   stb_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b1;
        else        sync_q[i] <= raw_n;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b1;
        else        sync_q[i] <= sync_q[i-1];
    end
  end

  wire synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
      stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (synced == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == DB_LAST) begin
        cnt_q <= '0;
        lvl_q <= synced;
        stb_q <= ~synced;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_n   = lvl_q;
  assign press_stb = stb_q;

  // R2: the filtered level moves only once the counter has run its full span
  assert_db_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(cnt_q) == DB_LAST);
  // R2: a press strobe always coincides with a pressed filtered level
  assert_stb_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> !lvl_q);
endmodule

// File: rtl/pwrbtn_hold_timer.sv
module pwrbtn_hold_timer #(
  parameter int HOLD_CYCLES = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_n,
  output logic ovr_pulse
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_MAX  = HW'(HOLD_CYCLES);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  logic [HW-1:0] hold_q;
  logic          ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ovr_q <= !level_n && (hold_q == HOLD_LAST);
      if (level_n)                hold_q <= '0;
      else if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
    end
  end

  assign ovr_pulse = ovr_q;

  // R5: counter saturates at its limit
  assert_hold_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= HOLD_MAX);
  // R5: the override pulse appears exactly as the counter reaches its limit
  assert_ovr_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> hold_q == HOLD_MAX);
  // R6: a released button leaves a cleared count on the next edge
  assert_release_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level_n |=> hold_q == '0);
  // R7: single-cycle override
  assert_ovr_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> !ovr_q);
endmodule

// File: rtl/pwrbtn_classify.sv
module pwrbtn_classify
  import pwrbtn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       press_stb,
  input  logic [1:0] sys_state,
  output logic       sleep_req,
  output logic       wake_evt
);
  pwr_state_e st;
  logic sleep_q, wake_q;

  assign st = pwr_state_e'(sys_state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      sleep_q <= press_stb && (st == PST_RUN);
      wake_q  <= press_stb && (st != PST_RUN);
    end
  end

  assign sleep_req = sleep_q;
  assign wake_evt  = wake_q;

  // R3: a sleep request follows a press taken while running
  assert_sleep_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> $past(press_stb) && $past(sys_state) == 2'b00);
  // R4: a wake event follows a press taken while sleeping
  assert_wake_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(press_stb) && $past(sys_state) != 2'b00);
  // R7: single-cycle, mutually exclusive pulses
  assert_sleep_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |=> !sleep_q);
  assert_wake_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_q && wake_q));
endmodule

// File: rtl/pwrbtn_event_ctrl.sv
module pwrbtn_event_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DB_CYCLES   = 16000,
  parameter int HOLD_CYCLES = 4000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_n,
  input  logic [1:0] sys_state,
  output logic       sleep_req,
  output logic       wake_evt,
  output logic       force_off
);
  logic level_n, press_stb;

  pwrbtn_debounce #(.SYNC_STAGES(SYNC_STAGES), .DB_CYCLES(DB_CYCLES)) u_debounce (
    .clk(clk), .rst_n(rst_n), .raw_n(btn_n),
    .level_n(level_n), .press_stb(press_stb));

  pwrbtn_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .level_n(level_n), .ovr_pulse(force_off));

  pwrbtn_classify u_classify (
    .clk(clk), .rst_n(rst_n), .press_stb(press_stb), .sys_state(sys_state),
    .sleep_req(sleep_req), .wake_evt(wake_evt));

  // R1: outputs quiet in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(sleep_req || wake_evt || force_off));
endmodule

// File: tb/pwrbtn_event_ctrl_bench.sv
`timescale 1ns/1ps
module pwrbtn_event_ctrl_bench;
  localparam int DB   = 8;
  localparam int HOLD = 40;

  logic clk = 1'b0, rst_n = 1'b0, btn_n = 1'b1;
  logic [1:0] sys_state = 2'b00;
  logic sleep_req, wake_evt, force_off;

  int checks = 0, failures = 0;
  int n_sleep = 0, n_wake = 0, n_ovr = 0, width_err = 0;
  logic p_sleep = 0, p_wake = 0, p_ovr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwrbtn_event_ctrl #(.SYNC_STAGES(2), .DB_CYCLES(DB), .HOLD_CYCLES(HOLD)) u_pwrbtn_event_ctrl (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .sys_state(sys_state),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .force_off(force_off));

  always @(negedge clk) begin
    if (rst_n) begin
      if (sleep_req) n_sleep++;
      if (wake_evt)  n_wake++;
      if (force_off) n_ovr++;
      if ((sleep_req && p_sleep) || (wake_evt && p_wake) || (force_off && p_ovr) ||
          (sleep_req && wake_evt)) width_err++;
    end
    p_sleep = sleep_req; p_wake = wake_evt; p_ovr = force_off;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sleep(int h, logic [1:0] st);
    return (h >= DB && st == 2'b00) ? 1 : 0;
  endfunction
  function automatic int exp_wake(int h, logic [1:0] st);
    return (h >= DB && st != 2'b00) ? 1 : 0;
  endfunction
  function automatic int exp_ovr(int h);
    return (h >= HOLD) ? 1 : 0;
  endfunction

  // hold the button low for exactly h sampling edges, then release and settle
  task automatic press(int h, logic [1:0] st, string tag);
    int s0, w0, o0;
    @(negedge clk);
    sys_state = st;
    s0 = n_sleep; w0 = n_wake; o0 = n_ovr;
    btn_n = 1'b0;
    repeat (h) @(negedge clk);
    btn_n = 1'b1;
    repeat (DB + 10) @(negedge clk);
    check({tag, " sleep"}, n_sleep - s0, exp_sleep(h, st));
    check({tag, " wake"},  n_wake - w0,  exp_wake(h, st));
    check({tag, " ovr"},   n_ovr - o0,   exp_ovr(h));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    // R1: idle high input after reset gives no events
    check("R1 quiet after reset", n_sleep + n_wake + n_ovr, 0);
    check("R1 sleep_req low", int'(sleep_req), 0);

    press(DB - 1, 2'b00, "R2 short glitch");
    press(1, 2'b01, "R2 one-cycle glitch");
    press(DB, 2'b00, "R3 minimum press running");
    press(DB + 5, 2'b01, "R4 press in S3");
    press(DB + 5, 2'b10, "R4 press in S4");
    press(DB + 5, 2'b11, "R4 press in S5");
    press(HOLD, 2'b01, "R5 hold exactly limit");
    press(HOLD - 1, 2'b00, "R6 hold one short of limit");
    press(HOLD - 1, 2'b10, "R6 second short hold after clear");
    press(3 * HOLD, 2'b00, "R5 long hold no repeat");
    press(3 * HOLD, 2'b10, "R5 long hold from S4");

    for (int i = 0; i < 40; i++) begin
      int h;
      logic [1:0] st;
      h  = 1 + int'($urandom_range(HOLD + 20));
      st = 2'($urandom_range(3));
      press(h, st, "R3/R4/R5 random");
    end

    check("R7 pulse width and exclusivity", width_err, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule